// File: doc/BRIEF.md
# Parallel Host Read/Write Port for a Six-Channel Sampler

This block is the parallel host side of a six-channel simultaneous-sampling converter. After a conversion ends, the host lowers chip-select and pulses read once for each result. The port hands out only the channels whose pair took part in the last conversion, lowest channel first. Once the last of those has been read, further reads return zero. Results can be presented as full 16-bit words. In byte mode each result is split into two reads, and both halves come out on the upper byte lane in an order the host selects. Results at 14-bit and 12-bit resolution are masked to their width, with zeros in the top bits.

The same bus carries writes into an 8-bit control register through its upper byte. Strobes and bus data are sampled in the system clock and edge-detected there. Tri-state behaviour is modelled by an output-enable port. While the bus is not enabled, the data port is forced to zero.

Top module: `par_host_port`

## Requirements
- R1: After reset, `bus_oe` is 0, all control outputs are 0, and a read before any conversion returns 0x0000.
- R2: `bus_oe` is 1 only when the previous clock sampled both `cs_n` and `rd_n` low. While `bus_oe` is 0, `bus_out` is 0x0000.
- R3: Channel c belongs to pair c/2, and `conv_pairs[p]` marks pair p as converted. Each completed read (a rising edge of `rd_n` with `cs_n` low) steps to the next converted channel in ascending order and skips channels of pairs that did not convert.
- R4: A read after the last converted channel returns 0x0000.
- R5: A falling edge of `busy` latches `conv_pairs` and places the read position on the lowest converted channel, whatever was read before.
- R6: `res_sel` 00 gives the full 16-bit word. 01 keeps bits [13:0] with bits [15:14] zero. 10 or 11 keeps bits [11:0] with bits [15:12] zero.
- R7: With `byte_mode` = 1, each result takes two reads, with the byte on `bus_out[15:8]` and `bus_out[7:0]` zero. `hi_first` = 1 returns the high byte first. `hi_first` = 0 returns the low byte first.
- R8: In byte mode with all three pairs converted, exactly 12 reads return data and the 13th returns 0x0000.
- R9: A write is taken on a rising edge of `wr_n` while `cs_n` is low and `rd_n` is high. `bus_in[15:8]` lands as {`ctrl_pairs`[2:0], `ctrl_ranges`[2:0], `ctrl_iref_en`, `ctrl_refbuf_dis`}, from bit 15 down to bit 8. The control outputs do not change while `wr_n` is still low.
- R10: A `wr_n` pulse while `cs_n` is high, or while `rd_n` is low, leaves the control outputs unchanged.
- R11: An `rd_n` pulse while `cs_n` is high does not advance the read position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy | input | 1 | Conversion in progress; falling edge starts a new read-out |
| conv_pairs | input | 3 | Pairs that took part in the conversion, sampled at the busy falling edge |
| res_sel | input | 2 | Result width: 00 = 16, 01 = 14, 1x = 12 bits |
| byte_mode | input | 1 | 1 = two byte reads per result |
| hi_first | input | 1 | In byte mode, 1 = high byte is read first |
| results | input | 96 | Six latched results, channel c at bits [16c+15:16c] |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| bus_in | input | 16 | Bus value seen by the port during writes |
| bus_out | output | 16 | Value driven on the bus |
| bus_oe | output | 1 | Bus output enable (0 = high impedance) |
| ctrl_pairs | output | 3 | Control register pair-select field |
| ctrl_ranges | output | 3 | Control register per-pair range field |
| ctrl_iref_en | output | 1 | Control register internal reference enable |
| ctrl_refbuf_dis | output | 1 | Control register reference buffer disable |

## Verification
If the read position is wrong, the very next read shows it. Either a channel of an unconverted pair comes out, the same word appears twice, or zero is returned too early or too late. If the byte-half flag is wrong, the byte order swaps on that read, or a byte pair gets split across two channels. A control register that follows the wrong strobe, or that takes data at the wrong moment, changes the control outputs within a few clocks of the offending pulse. The bench therefore checks the outputs both during a write and after it.

// File: rtl/hp_pkg.sv
package hp_pkg;
  localparam int WORD_W   = 16;
  localparam int BYTE_W   = 8;
  localparam int MID_BITS = 14;
  localparam int LOW_BITS = 12;

  typedef enum logic [1:0] {
    RES_FULL = 2'b00,
    RES_MID  = 2'b01,
    RES_LOW  = 2'b10,
    RES_LOW2 = 2'b11
  } res_e;

  // bits of the word that survive at a given resolution
  function automatic logic [WORD_W-1:0] keep_mask(input logic [1:0] res);
    logic [WORD_W-1:0] m;
    m = '1;
    case (res_e'(res))
      RES_FULL: m = '1;
      RES_MID:  m = m >> (WORD_W - MID_BITS);
      default:  m = m >> (WORD_W - LOW_BITS);
    endcase
    return m;
  endfunction

  function automatic logic [WORD_W-1:0] fmt_result(input logic [WORD_W-1:0] w,
                                                   input logic [1:0] res);
    return w & keep_mask(res);
  endfunction

  // which half of a result a byte-mode read returns
  function automatic logic [BYTE_W-1:0] pick_byte(input logic [WORD_W-1:0] w,
                                                  input logic second,
                                                  input logic hi_first);
    logic take_hi;
    take_hi = second ? ~hi_first : hi_first;
    return take_hi ? w[WORD_W-1 -: BYTE_W] : w[BYTE_W-1:0];
  endfunction
endpackage

// File: rtl/hp_strobe_sync.sv
module hp_strobe_sync #(
  parameter int CTRL_W = 8,
  parameter int BUS_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [BUS_W-1:0]  bus_in,
  output logic              drive_en,
  output logic              rd_done,
  output logic              wr_done,
  output logic [CTRL_W-1:0] wr_byte
);
  logic cs_s1, rd_s1, wr_s1;
  logic cs_s2, rd_s2, wr_s2;
  logic [CTRL_W-1:0] hi_s1, hi_s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_s1 <= 1'b1; rd_s1 <= 1'b1; wr_s1 <= 1'b1;
      cs_s2 <= 1'b1; rd_s2 <= 1'b1; wr_s2 <= 1'b1;
      hi_s1 <= '0;   hi_s2 <= '0;
    end else begin
      cs_s1 <= cs_n; rd_s1 <= rd_n; wr_s1 <= wr_n;
      cs_s2 <= cs_s1; rd_s2 <= rd_s1; wr_s2 <= wr_s1;
      hi_s1 <= bus_in[BUS_W-1 -: CTRL_W];
      hi_s2 <= hi_s1;
    end
  end

  assign drive_en = ~cs_s1 & ~rd_s1;
  // read completes when rd rises after a selected low phase
  assign rd_done  = rd_s1 & ~rd_s2 & ~cs_s2;
  // write completes when wr rises after a selected, non-read low phase
  assign wr_done  = wr_s1 & ~wr_s2 & ~cs_s2 & rd_s2;
  assign wr_byte  = hi_s2;
endmodule

// File: rtl/hp_read_seq.sv
module hp_read_seq #(
  parameter int NUM_PAIRS   = 3,
  parameter int CH_PER_PAIR = 2,
  parameter int PTR_W       = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 busy,
  input  logic [NUM_PAIRS-1:0] conv_pairs,
  input  logic                 byte_mode,
  input  logic                 rd_done,
  output logic [PTR_W-1:0]     ptr,
  output logic                 half,
  output logic                 busy_fall
);
  localparam int NUM_CH = NUM_PAIRS * CH_PER_PAIR;
  localparam logic [PTR_W-1:0] PTR_END = PTR_W'(NUM_CH);

  logic                 busy_q;
  logic [NUM_PAIRS-1:0] pairs_q;

  // lowest converted channel at or above start, PTR_END if none
  function automatic logic [PTR_W-1:0] next_live(input int start,
                                                 input logic [NUM_PAIRS-1:0] m);
    logic [PTR_W-1:0] r;
    r = PTR_END;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (c >= start && m[c / CH_PER_PAIR]) r = PTR_W'(c);
    end
    return r;
  endfunction

  assign busy_fall = busy_q & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      pairs_q <= '0;
      ptr     <= PTR_END;
      half    <= 1'b0;
    end else begin
      busy_q <= busy;
      if (busy_fall) begin
        pairs_q <= conv_pairs;
        ptr     <= next_live(0, conv_pairs);
        half    <= 1'b0;
      end else if (rd_done && ptr != PTR_END) begin
        if (byte_mode && !half) begin
          half <= 1'b1;
        end else begin
          half <= 1'b0;
          ptr  <= next_live(int'(ptr) + 1, pairs_q);
        end
      end
    end
  end
endmodule

// File: rtl/hp_formatter.sv
module hp_formatter
  import hp_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int PTR_W  = 3
) (
  input  logic [NUM_CH*WORD_W-1:0] results,
  input  logic [PTR_W-1:0]         ptr,
  input  logic                     half,
  input  logic                     byte_mode,
  input  logic                     hi_first,
  input  logic [1:0]               res_sel,
  input  logic                     drive_en,
  output logic [WORD_W-1:0]        bus_out
);
  logic [WORD_W-1:0] raw;
  logic              hit;
  logic [WORD_W-1:0] shaped;

  always_comb begin
    raw = '0;
    hit = 1'b0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (ptr == PTR_W'(c)) begin
        raw = results[c*WORD_W +: WORD_W];
        hit = 1'b1;
      end
    end
  end

  assign shaped = fmt_result(raw, res_sel);

  always_comb begin
    if (!drive_en || !hit)
      bus_out = '0;
    else if (byte_mode)
      bus_out = {pick_byte(shaped, half, hi_first), {(WORD_W-BYTE_W){1'b0}}};
    else
      bus_out = shaped;
  end
endmodule

// File: rtl/hp_ctrl_reg.sv
module hp_ctrl_reg #(
  parameter int CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_done,
  input  logic [CTRL_W-1:0] wr_byte,
  output logic [CTRL_W-1:0] ctrl_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_done) ctrl_q <= wr_byte;
  end
endmodule

// File: rtl/par_host_port.sv
module par_host_port
  import hp_pkg::*;
#(
  parameter int NUM_PAIRS   = 3,
  parameter int CH_PER_PAIR = 2
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   busy,
  input  logic [NUM_PAIRS-1:0]                   conv_pairs,
  input  logic [1:0]                             res_sel,
  input  logic                                   byte_mode,
  input  logic                                   hi_first,
  input  logic [NUM_PAIRS*CH_PER_PAIR*WORD_W-1:0] results,
  input  logic                                   cs_n,
  input  logic                                   rd_n,
  input  logic                                   wr_n,
  input  logic [WORD_W-1:0]                      bus_in,
  output logic [WORD_W-1:0]                      bus_out,
  output logic                                   bus_oe,
  output logic [NUM_PAIRS-1:0]                   ctrl_pairs,
  output logic [NUM_PAIRS-1:0]                   ctrl_ranges,
  output logic                                   ctrl_iref_en,
  output logic                                   ctrl_refbuf_dis
);
  localparam int NUM_CH = NUM_PAIRS * CH_PER_PAIR;
  localparam int PTR_W  = $clog2(NUM_CH + 1);
  localparam int CTRL_W = 2 * NUM_PAIRS + 2;

  logic              drive_en, rd_done, wr_done, busy_fall, rd_half;
  logic [CTRL_W-1:0] wr_byte, ctrl_q;
  logic [PTR_W-1:0]  rd_ptr;

  hp_strobe_sync #(.CTRL_W(CTRL_W), .BUS_W(WORD_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .bus_in(bus_in), .drive_en(drive_en), .rd_done(rd_done),
    .wr_done(wr_done), .wr_byte(wr_byte)
  );

  hp_read_seq #(.NUM_PAIRS(NUM_PAIRS), .CH_PER_PAIR(CH_PER_PAIR), .PTR_W(PTR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .busy(busy), .conv_pairs(conv_pairs),
    .byte_mode(byte_mode), .rd_done(rd_done), .ptr(rd_ptr),
    .half(rd_half), .busy_fall(busy_fall)
  );

  hp_formatter #(.NUM_CH(NUM_CH), .PTR_W(PTR_W)) u_fmt (
    .results(results), .ptr(rd_ptr), .half(rd_half), .byte_mode(byte_mode),
    .hi_first(hi_first), .res_sel(res_sel), .drive_en(drive_en),
    .bus_out(bus_out)
  );

  hp_ctrl_reg #(.CTRL_W(CTRL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_done(wr_done), .wr_byte(wr_byte),
    .ctrl_q(ctrl_q)
  );

  assign bus_oe          = drive_en;
  assign ctrl_pairs      = ctrl_q[CTRL_W-1 -: NUM_PAIRS];
  assign ctrl_ranges     = ctrl_q[CTRL_W-1-NUM_PAIRS -: NUM_PAIRS];
  assign ctrl_iref_en    = ctrl_q[1];
  assign ctrl_refbuf_dis = ctrl_q[0];
endmodule

// File: rtl/par_host_port_chk.sv
module par_host_port_chk #(
  parameter int PTR_W  = 3,
  parameter int NUM_CH = 6,
  parameter int CTRL_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              rd_n,
  input logic              byte_mode,
  input logic [1:0]        res_sel,
  input logic [15:0]       bus_out,
  input logic              bus_oe,
  input logic [PTR_W-1:0]  ptr,
  input logic              half,
  input logic              busy_fall,
  input logic              rd_done,
  input logic              wr_done,
  input logic [CTRL_W-1:0] ctrl_q
);
  AST_OE_NEEDS_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> $past(!cs_n && !rd_n)); // R2
  AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> bus_out == 16'h0000); // R2
  AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= PTR_W'(NUM_CH)); // R3
  AST_PTR_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_fall |=> ptr >= $past(ptr)); // R3
  AST_WORD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && !busy_fall && !byte_mode && ptr != PTR_W'(NUM_CH)) |=> ptr > $past(ptr)); // R3
  AST_FALL_CLEARS_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    busy_fall |=> !half); // R5
  AST_MID_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && !byte_mode && res_sel == 2'b01) |-> bus_out[15:14] == 2'b00); // R6
  AST_BYTE_LOW_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_mode |-> bus_out[7:0] == 8'h00); // R7
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_done |=> $stable(ctrl_q)); // R10
endmodule

bind par_host_port par_host_port_chk #(.PTR_W(PTR_W), .NUM_CH(NUM_CH), .CTRL_W(CTRL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .byte_mode(byte_mode),
  .res_sel(res_sel), .bus_out(bus_out), .bus_oe(bus_oe), .ptr(rd_ptr),
  .half(rd_half), .busy_fall(busy_fall), .rd_done(rd_done),
  .wr_done(wr_done), .ctrl_q(ctrl_q)
);

// File: tb/par_host_port_bench.sv
module par_host_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        busy = 1'b0;
  logic [2:0]  conv_pairs = 3'b000;
  logic [1:0]  res_sel = 2'b00;
  logic        byte_mode = 1'b0;
  logic        hi_first = 1'b0;
  logic [95:0] results;
  logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [15:0] bus_in = 16'h0000;
  logic [15:0] bus_out;
  logic        bus_oe;
  logic [2:0]  ctrl_pairs, ctrl_ranges;
  logic        ctrl_iref_en, ctrl_refbuf_dis;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  par_host_port u_par_host_port (
    .clk(clk), .rst_n(rst_n), .busy(busy), .conv_pairs(conv_pairs),
    .res_sel(res_sel), .byte_mode(byte_mode), .hi_first(hi_first),
    .results(results), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .ctrl_pairs(ctrl_pairs), .ctrl_ranges(ctrl_ranges),
    .ctrl_iref_en(ctrl_iref_en), .ctrl_refbuf_dis(ctrl_refbuf_dis)
  );

  function automatic logic [15:0] word_of(input int c);
    return 16'(16'hF1E7 - c * 16'h2345);
  endfunction

  function automatic logic [15:0] expect_fmt(input logic [15:0] w, input logic [1:0] r);
    if (r == 2'b00) return w;
    if (r == 2'b01) return w % 16'h4000;
    return w % 16'h1000;
  endfunction

  function automatic logic [7:0] ctrl_now();
    return {ctrl_pairs, ctrl_ranges, ctrl_iref_en, ctrl_refbuf_dis};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_read(output logic [15:0] d, output logic oe);
    cs_n = 1'b0; rd_n = 1'b0;
    tick(3);
    d = bus_out; oe = bus_oe;
    rd_n = 1'b1;
    tick(3);
    cs_n = 1'b1;
    tick(1);
  endtask

  task automatic convert(input logic [2:0] mask);
    conv_pairs = mask; busy = 1'b1;
    tick(2);
    busy = 1'b0;
    tick(2);
  endtask

  task automatic bus_write(input logic [15:0] data, input logic csv, input logic rdv);
    cs_n = csv; rd_n = rdv; bus_in = data;
    tick(1);
    wr_n = 1'b0;
    tick(3);
    wr_n = 1'b1;
    tick(3);
    cs_n = 1'b1;
    tick(3);
    rd_n = 1'b1;
    tick(3);
  endtask

  task automatic t_reset();
    logic [15:0] d; logic oe;
    check(bus_oe == 1'b0, "R1 oe after reset", 16'(bus_oe), 16'h0);
    check(ctrl_now() == 8'h00, "R1 control after reset", 16'(ctrl_now()), 16'h0);
    do_read(d, oe);
    check(d == 16'h0000, "R1 read before conversion", d, 16'h0);
  endtask

  task automatic t_words(input logic [2:0] mask, input logic [1:0] r, input string tag);
    logic [15:0] d; logic oe;
    res_sel = r; byte_mode = 1'b0;
    convert(mask);
    for (int c = 0; c < 6; c++) begin
      if (mask[c/2]) begin
        do_read(d, oe);
        check(oe && d == expect_fmt(word_of(c), r), tag, d, expect_fmt(word_of(c), r));
      end
    end
    do_read(d, oe);
    check(d == 16'h0000, "R4 read past last channel", d, 16'h0);
  endtask

  task automatic t_restart();
    logic [15:0] d; logic oe;
    res_sel = 2'b00;
    convert(3'b111);
    do_read(d, oe);
    do_read(d, oe);
    convert(3'b110);
    do_read(d, oe);
    check(d == word_of(2), "R5 restart at first converted", d, word_of(2));
  endtask

  task automatic t_bytes(input logic hf);
    logic [15:0] d, w, e; logic oe;
    int reads;
    reads = 0;
    res_sel = 2'b00; byte_mode = 1'b1; hi_first = hf;
    convert(3'b111);
    for (int c = 0; c < 6; c++) begin
      w = word_of(c);
      for (int h = 0; h < 2; h++) begin
        do_read(d, oe);
        reads++;
        e = ((h == 0) == hf) ? {w[15:8], 8'h00} : {w[7:0], 8'h00};
        check(d == e, hf ? "R7 byte high first" : "R7 byte low first", d, e);
      end
    end
    do_read(d, oe);
    check(d == 16'h0000 && reads == 12, "R8 thirteenth byte read", d, 16'h0);
    byte_mode = 1'b0;
  endtask

  task automatic t_enable();
    cs_n = 1'b0; rd_n = 1'b1;
    tick(3);
    check(!bus_oe && bus_out == 16'h0, "R2 cs only", bus_out, 16'h0);
    cs_n = 1'b1;
    tick(2);
    rd_n = 1'b0;
    tick(3);
    check(!bus_oe && bus_out == 16'h0, "R2 rd only", bus_out, 16'h0);
    rd_n = 1'b1;
    tick(3);
  endtask

  task automatic t_unselected_read();
    logic [15:0] d; logic oe;
    res_sel = 2'b00;
    convert(3'b111);
    rd_n = 1'b0; tick(3); rd_n = 1'b1; tick(3);
    do_read(d, oe);
    check(d == word_of(0), "R11 deselected rd pulse", d, word_of(0));
  endtask

  task automatic t_ctrl();
    cs_n = 1'b0; bus_in = 16'hB700;
    tick(1);
    wr_n = 1'b0;
    tick(4);
    check(ctrl_now() == 8'h00, "R9 no capture while wr low", 16'(ctrl_now()), 16'h0);
    wr_n = 1'b1;
    tick(3);
    cs_n = 1'b1;
    tick(2);
    check(ctrl_now() == 8'hB7, "R9 capture on wr rise", 16'(ctrl_now()), 16'hB7);
    check(ctrl_pairs == 3'b101 && ctrl_ranges == 3'b101, "R9 field split",
          16'({ctrl_pairs, ctrl_ranges}), 16'h2D);
    bus_write(16'h4A00, 1'b0, 1'b1);
    check(ctrl_now() == 8'h4A, "R9 second write", 16'(ctrl_now()), 16'h4A);
    check(ctrl_iref_en && !ctrl_refbuf_dis, "R9 reference bits",
          16'({ctrl_iref_en, ctrl_refbuf_dis}), 16'h2);
    bus_write(16'hFF00, 1'b1, 1'b1);
    check(ctrl_now() == 8'h4A, "R10 write with cs high", 16'(ctrl_now()), 16'h4A);
    bus_write(16'h1100, 1'b0, 1'b0);
    check(ctrl_now() == 8'h4A, "R10 write with rd low", 16'(ctrl_now()), 16'h4A);
  endtask

  initial begin
    for (int c = 0; c < 6; c++) results[c*16 +: 16] = word_of(c);
    tick(3);
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_enable();
    t_words(3'b111, 2'b00, "R3 all pairs ascending");
    t_words(3'b101, 2'b00, "R3 skip middle pair");
    t_words(3'b010, 2'b00, "R3 middle pair only");
    t_words(3'b111, 2'b01, "R6 14-bit shaping");
    t_words(3'b011, 2'b10, "R6 12-bit shaping");
    t_words(3'b100, 2'b11, "R6 12-bit alt code");
    t_restart();
    t_bytes(1'b1);
    t_bytes(1'b0);
    t_unselected_read();
    t_ctrl();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule